// File: doc/BRIEF.md
# Serial interrupt cycle sequencer

This block is the host-side master for a shared, single-wire serial interrupt line. It runs on the bus clock and frames every cycle on the line. A cycle is a start pulse, a fixed run of three-clock data frames and a stop pulse. While the data frames run, it tells a separate decoder which frame and which phase is on the line. The line is open-drain, so the block only ever pulls it low. The same holds for the clock-run wire.

Two modes are supported. In continuous mode the block starts every cycle itself and leaves a fixed idle gap between cycles. A stop input can hold back the next start for as long as it is asserted. In quiet mode a peripheral begins the cycle by pulling the line low, and the block then completes the start pulse. The mode pin takes effect through a snapshot taken at the end of each start pulse, and any change on that pin forces a fresh cycle. The block also reports whether it is busy, answers a clock-run request while busy, and freezes completely while the shutdown input is low.

Top module: `sirq_cycle_seq`

## Requirements
- R1: While rst_ni is low, sirq_pull_o and clkrun_pull_o are 0 and idle_o is 1. On the first clock after reset is released, the block starts a cycle itself, whatever level poll_mode_i has.
- R2: A start pulse the block begins on its own holds sirq_pull_o at 1 for exactly 8 consecutive clocks.
- R3: After the start pulse, the line is released for 2 clocks. Then come 21 data frames of 3 clocks each. During these frames frame_valid_o is 1, frame_idx_o counts from 0 to 20, phase_o reads 0 for sample, 1 for recovery and 2 for turnaround, and sirq_pull_o is 0.
- R4: Right after the last data frame, the stop pulse pulls the line for 3 clocks if the snapshot mode is continuous (poll_mode_i = 1), or for 2 clocks if it is quiet (poll_mode_i = 0). The line is then released for 2 clocks.
- R5: The mode snapshot is taken on the last clock of the start pulse. A change made earlier in that pulse sets the current stop width and causes no extra cycle. A change made after the start pulse applies from the next cycle.
- R6: A change of poll_mode_i starts a new cycle as soon as the current one has finished its stop frame, with no idle gap. If no cycle is running, the new cycle starts on the next clock.
- R7: In continuous mode there are 17 released idle clocks between the end of the stop frame and the next start pulse. Start pulses therefore begin 95 clocks apart.
- R8: If stop_ni is low at any clock of a running cycle, the block finishes that cycle and then stays idle. It begins the next start pulse on the clock after it samples stop_ni high.
- R9: In quiet mode with no cycle running, the block pulls nothing until it samples sirq_i low. It then pulls the line for the next 7 clocks.
- R10: idle_o falls one clock after the block begins pulling a start pulse. It rises on the second clock after the last stop-pulse clock.
- R11: When idle_o is low and the block samples clkrun_i high, clkrun_pull_o is 1 for the next 2 clocks and then 0. When idle_o is high, clkrun_i gets no reply.
- R12: While shutdown_ni is low, sirq_pull_o, clkrun_pull_o and frame_valid_o are 0 and every sequencing state holds. When shutdown_ni returns high, the cycle resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shutdown_ni | input | 1 | Low freezes the sequencer and releases all pulls |
| poll_mode_i | input | 1 | 1 = continuous mode, 0 = quiet mode |
| stop_ni | input | 1 | Low holds off continuous restarts after the current cycle |
| sirq_i | input | 1 | Sampled level of the serial interrupt line |
| sirq_pull_o | output | 1 | 1 pulls the serial interrupt line low |
| clkrun_i | input | 1 | Sampled level of the clock-run line |
| clkrun_pull_o | output | 1 | 1 pulls the clock-run line low |
| idle_o | output | 1 | 1 when no cycle is in progress |
| frame_valid_o | output | 1 | A data frame is on the line |
| frame_idx_o | output | 5 | Data frame number, 0 to 20 |
| phase_o | output | 2 | Frame phase: 0 sample, 1 recovery, 2 turnaround |

## Verification
Most faults in the state counter show up as a misplaced edge on sirq_pull_o or on idle_o. An off-by-one in the start, stop or gap length shifts the next edge by one clock within the same cycle. A wrong frame or phase count shows on frame_idx_o and phase_o within three clocks of entering the data frames, and it moves the stop pulse. A mode snapshot taken at the wrong moment only appears at the stop pulse about 65 clocks later, or as an extra or missing start pulse. The stop-hold and clock-run flags are visible as a missing or extra start, or pull, within one or two clocks of the stimulus.

// File: rtl/sirq_seq_pkg.sv
`timescale 1ns/1ps
package sirq_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START,
    S_SREC,
    S_STA,
    S_DATA,
    S_STOP,
    S_PREC,
    S_PTA,
    S_GAP
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_SAMPLE  = 2'd0,
    PH_RECOVER = 2'd1,
    PH_TURN    = 2'd2
  } frame_phase_e;

endpackage

// File: rtl/sirq_mode_track.sv
`timescale 1ns/1ps
module sirq_mode_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic mode_i,
  input  logic latch_i,
  output logic mode_lat_o,
  output logic change_pend_o
);

  logic prev_q, lat_q, pend_q;

  // reset state: continuous, with a start already owed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      lat_q  <= 1'b1;
      pend_q <= 1'b1;
    end else if (en_i) begin
      prev_q <= mode_i;
      if (latch_i) begin
        lat_q  <= mode_i;
        pend_q <= 1'b0;
      end else begin
        pend_q <= pend_q | (mode_i != prev_q);
      end
    end
  end

  assign mode_lat_o    = lat_q;
  assign change_pend_o = pend_q;

endmodule

// File: rtl/sirq_frame_cnt.sv
`timescale 1ns/1ps
module sirq_frame_cnt
  import sirq_seq_pkg::*;
#(
  parameter int NUM_FRAMES = 21,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             run_i,
  output logic [IDX_W-1:0] idx_o,
  output frame_phase_e     phase_o,
  output logic             last_o
);

  logic [IDX_W-1:0] idx_q;
  frame_phase_e     ph_q;

  assign last_o = run_i && (idx_q == IDX_W'(NUM_FRAMES - 1)) && (ph_q == PH_TURN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ph_q  <= PH_SAMPLE;
    end else if (en_i) begin
      if (!run_i || last_o) begin
        idx_q <= '0;
        ph_q  <= PH_SAMPLE;
      end else begin
        unique case (ph_q)
          PH_SAMPLE:  ph_q <= PH_RECOVER;
          PH_RECOVER: ph_q <= PH_TURN;
          default: begin
            ph_q  <= PH_SAMPLE;
            idx_q <= idx_q + 1'b1;
          end
        endcase
      end
    end
  end

  assign idx_o   = idx_q;
  assign phase_o = ph_q;

endmodule

// File: rtl/sirq_clkrun_reply.sv
`timescale 1ns/1ps
module sirq_clkrun_reply #(
  parameter int PULSE_CLKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic busy_i,
  input  logic clkrun_i,
  output logic pull_o
);

  generate
    if (PULSE_CLKS == 1) begin : g_single
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= 1'b0;
        else if (en_i) q <= !q && busy_i && clkrun_i;
      end
      assign pull_o = q;
    end else begin : g_count
      localparam int W = $clog2(PULSE_CLKS + 1);
      logic [W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
        end else if (en_i) begin
          if (cnt_q != '0)              cnt_q <= cnt_q - 1'b1;
          else if (busy_i && clkrun_i)  cnt_q <= W'(PULSE_CLKS);
        end
      end
      assign pull_o = (cnt_q != '0);
    end
  endgenerate

endmodule

// File: rtl/sirq_cycle_seq.sv
`timescale 1ns/1ps
module sirq_cycle_seq
  import sirq_seq_pkg::*;
#(
  parameter int START_CLKS      = 8,
  parameter int NUM_FRAMES      = 21,
  parameter int STOP_QUIET_CLKS = 2,
  parameter int STOP_CONT_CLKS  = 3,
  parameter int GAP_CLKS        = 17,
  parameter int CLKRUN_CLKS     = 2,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shutdown_ni,
  input  logic             poll_mode_i,
  input  logic             stop_ni,
  input  logic             sirq_i,
  output logic             sirq_pull_o,
  input  logic             clkrun_i,
  output logic             clkrun_pull_o,
  output logic             idle_o,
  output logic             frame_valid_o,
  output logic [IDX_W-1:0] frame_idx_o,
  output logic [1:0]       phase_o
);

  localparam int MAX_A   = (START_CLKS > GAP_CLKS) ? START_CLKS : GAP_CLKS;
  localparam int MAX_B   = (STOP_CONT_CLKS > STOP_QUIET_CLKS) ? STOP_CONT_CLKS : STOP_QUIET_CLKS;
  localparam int CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en, latch, mode_lat, chg_pend, last_frame;
  logic             stop_req_q, idle_q, busy_set, in_cycle, enter_start, cr_pull;
  frame_phase_e     ph;
  logic [IDX_W-1:0] idx;

  assign en = shutdown_ni;

  sirq_mode_track u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .mode_i       (poll_mode_i),
    .latch_i      (latch),
    .mode_lat_o   (mode_lat),
    .change_pend_o(chg_pend)
  );

  sirq_frame_cnt #(.NUM_FRAMES(NUM_FRAMES)) u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .run_i  (state_q == S_DATA),
    .idx_o  (idx),
    .phase_o(ph),
    .last_o (last_frame)
  );

  sirq_clkrun_reply #(.PULSE_CLKS(CLKRUN_CLKS)) u_clkrun (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .busy_i  (!idle_q),
    .clkrun_i(clkrun_i),
    .pull_o  (cr_pull)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    latch   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (!poll_mode_i && !sirq_i) begin
          // peripheral already spent one clock of the start pulse
          state_d = S_START;
          cnt_d   = CNT_W'(START_CLKS - 2);
        end else if (chg_pend || (poll_mode_i && stop_ni)) begin
          state_d = S_START;
          cnt_d   = CNT_W'(START_CLKS - 1);
        end
      end
      S_START: begin
        if (cnt_q == '0) begin
          state_d = S_SREC;
          latch   = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      S_SREC: state_d = S_STA;
      S_STA:  state_d = S_DATA;
      S_DATA: begin
        if (last_frame) begin
          state_d = S_STOP;
          cnt_d   = mode_lat ? CNT_W'(STOP_CONT_CLKS - 1) : CNT_W'(STOP_QUIET_CLKS - 1);
        end
      end
      S_STOP: begin
        if (cnt_q == '0) state_d = S_PREC;
        else             cnt_d   = cnt_q - 1'b1;
      end
      S_PREC: state_d = S_PTA;
      S_PTA: begin
        if (chg_pend) begin
          state_d = S_START;
          cnt_d   = CNT_W'(START_CLKS - 1);
        end else if (mode_lat && !stop_req_q) begin
          state_d = S_GAP;
          cnt_d   = CNT_W'(GAP_CLKS - 1);
        end else begin
          state_d = S_IDLE;
        end
      end
      S_GAP: begin
        if (chg_pend || (cnt_q == '0 && stop_ni)) begin
          state_d = S_START;
          cnt_d   = CNT_W'(START_CLKS - 1);
        end else if (cnt_q == '0) begin
          state_d = S_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign in_cycle    = (state_q != S_IDLE) && (state_q != S_GAP);
  assign enter_start = (state_d == S_START) && (state_q != S_START);
  assign busy_set    = (state_q == S_START) || (state_q == S_SREC) || (state_q == S_STA) ||
                       (state_q == S_DATA)  || (state_q == S_STOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      stop_req_q <= 1'b0;
      idle_q     <= 1'b1;
    end else if (en) begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      idle_q     <= !busy_set;
      if (enter_start)               stop_req_q <= 1'b0;
      else if (in_cycle && !stop_ni) stop_req_q <= 1'b1;
    end
  end

  assign sirq_pull_o   = en && ((state_q == S_START) || (state_q == S_STOP));
  assign clkrun_pull_o = en && cr_pull;
  assign idle_o        = idle_q;
  assign frame_valid_o = en && (state_q == S_DATA);
  assign frame_idx_o   = idx;
  assign phase_o       = ph;

endmodule

// File: rtl/sirq_cycle_seq_chk.sv
`timescale 1ns/1ps
module sirq_cycle_seq_chk #(
  parameter int START_CLKS  = 8,
  parameter int CLKRUN_CLKS = 2,
  parameter int IDX_W       = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             shutdown_ni,
  input logic             sirq_pull_o,
  input logic             clkrun_pull_o,
  input logic             idle_o,
  input logic             frame_valid_o,
  input logic [IDX_W-1:0] frame_idx_o,
  input logic [1:0]       phase_o
);

  localparam int RUN_W = $clog2(START_CLKS + 2);
  localparam int CR_W  = $clog2(CLKRUN_CLKS + 2);

  logic [RUN_W-1:0] pull_run;
  logic [CR_W-1:0]  cr_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pull_run <= '0;
      cr_run   <= '0;
    end else begin
      if (!sirq_pull_o)                  pull_run <= '0;
      else if (pull_run != RUN_W'(START_CLKS + 1)) pull_run <= pull_run + 1'b1;
      if (!clkrun_pull_o)                cr_run <= '0;
      else if (cr_run != CR_W'(CLKRUN_CLKS + 1)) cr_run <= cr_run + 1'b1;
    end
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_released : assert (!sirq_pull_o && !clkrun_pull_o && idle_o);
    end
  end

  // R2: no pull run exceeds a start pulse
  a_r2_pull_max : assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_run <= RUN_W'(START_CLKS));

  a_r3_phase_step : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_o && phase_o == 2'd0) |=> (phase_o == 2'd1 && $stable(frame_idx_o)));

  a_r3_line_free : assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> !sirq_pull_o);

  a_r10_busy_while_pulling : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sirq_pull_o && $past(sirq_pull_o)) |-> !idle_o);

  a_r11_clkrun_len : assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_run <= CR_W'(CLKRUN_CLKS));

  a_r12_freeze : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shutdown_ni |=> ($stable(frame_idx_o) && $stable(phase_o) && $stable(idle_o)));

endmodule

bind sirq_cycle_seq sirq_cycle_seq_chk #(
  .START_CLKS (START_CLKS),
  .CLKRUN_CLKS(CLKRUN_CLKS),
  .IDX_W      (IDX_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .shutdown_ni  (shutdown_ni),
  .sirq_pull_o  (sirq_pull_o),
  .clkrun_pull_o(clkrun_pull_o),
  .idle_o       (idle_o),
  .frame_valid_o(frame_valid_o),
  .frame_idx_o  (frame_idx_o),
  .phase_o      (phase_o)
);

// File: tb/sirq_cycle_seq_test.sv
`timescale 1ns/1ps
module sirq_cycle_seq_test;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       shutdown_ni = 1'b1;
  logic       poll_mode_i = 1'b1;
  logic       stop_ni = 1'b1;
  logic       periph_low = 1'b0;
  logic       clkrun_req = 1'b0;
  logic       sirq_i, clkrun_i;
  logic       sirq_pull_o, clkrun_pull_o, idle_o, frame_valid_o;
  logic [4:0] frame_idx_o;
  logic [1:0] phase_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  // open-drain line models
  assign sirq_i   = !(periph_low || sirq_pull_o);
  assign clkrun_i = clkrun_req && !clkrun_pull_o;

  sirq_cycle_seq uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .shutdown_ni  (shutdown_ni),
    .poll_mode_i  (poll_mode_i),
    .stop_ni      (stop_ni),
    .sirq_i       (sirq_i),
    .sirq_pull_o  (sirq_pull_o),
    .clkrun_i     (clkrun_i),
    .clkrun_pull_o(clkrun_pull_o),
    .idle_o       (idle_o),
    .frame_valid_o(frame_valid_o),
    .frame_idx_o  (frame_idx_o),
    .phase_o      (phase_o)
  );

  // {offset[7:0], pull, idle, valid, idx[4:0], phase[1:0]} for one continuous cycle after reset
  localparam int NV = 18;
  localparam logic [17:0] VEC [NV] = '{
    {8'd0,  1'b1, 1'b1, 1'b0, 5'd0,  2'd0},
    {8'd1,  1'b1, 1'b0, 1'b0, 5'd0,  2'd0},
    {8'd7,  1'b1, 1'b0, 1'b0, 5'd0,  2'd0},
    {8'd8,  1'b0, 1'b0, 1'b0, 5'd0,  2'd0},
    {8'd9,  1'b0, 1'b0, 1'b0, 5'd0,  2'd0},
    {8'd10, 1'b0, 1'b0, 1'b1, 5'd0,  2'd0},
    {8'd11, 1'b0, 1'b0, 1'b1, 5'd0,  2'd1},
    {8'd12, 1'b0, 1'b0, 1'b1, 5'd0,  2'd2},
    {8'd13, 1'b0, 1'b0, 1'b1, 5'd1,  2'd0},
    {8'd40, 1'b0, 1'b0, 1'b1, 5'd10, 2'd0},
    {8'd72, 1'b0, 1'b0, 1'b1, 5'd20, 2'd2},
    {8'd73, 1'b1, 1'b0, 1'b0, 5'd0,  2'd0},
    {8'd75, 1'b1, 1'b0, 1'b0, 5'd0,  2'd0},
    {8'd76, 1'b0, 1'b0, 1'b0, 5'd0,  2'd0},
    {8'd77, 1'b0, 1'b1, 1'b0, 5'd0,  2'd0},
    {8'd94, 1'b0, 1'b1, 1'b0, 5'd0,  2'd0},
    {8'd95, 1'b1, 1'b1, 1'b0, 5'd0,  2'd0},
    {8'd96, 1'b1, 1'b0, 1'b0, 5'd0,  2'd0}
  };

  function automatic string tag_of(int off);
    if (off == 0)                 return "R1";
    if (off == 1 || off == 96)    return "R10";
    if (off < 10)                 return "R2";
    if (off < 73)                 return "R3";
    if (off < 77)                 return "R4";
    if (off == 77)                return "R10";
    return "R7";
  endfunction

  task automatic chk(string req, bit ok, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: act=%0h exp=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic wait_to(int t);
    while (cyc < t) begin
      @(negedge clk_i);
      cyc++;
    end
  endtask

  task automatic chk_pull(string req, bit exp);
    chk(req, sirq_pull_o == exp, int'(sirq_pull_o), int'(exp));
  endtask

  task automatic chk_idle(string req, bit exp);
    chk(req, idle_o == exp, int'(idle_o), int'(exp));
  endtask

  initial begin
    int a, b, c, f, g;
    // R1: reset state
    repeat (3) @(negedge clk_i);
    clkrun_req = 1'b1;
    @(negedge clk_i);
    chk("R1", !sirq_pull_o && !clkrun_pull_o && idle_o,
        {sirq_pull_o, clkrun_pull_o, idle_o}, 3'b001);
    clkrun_req = 1'b0;
    rst_ni = 1'b1;
    cyc = -1;

    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      logic [9:0]  act, exp;
      v = VEC[i];
      wait_to(int'(v[17:10]));
      exp = {v[9], v[8], v[7], v[7] ? v[6:2] : 5'd0, v[7] ? v[1:0] : 2'd0};
      act = {sirq_pull_o, idle_o, frame_valid_o,
             frame_valid_o ? frame_idx_o : 5'd0, frame_valid_o ? phase_o : 2'd0};
      chk(tag_of(int'(v[17:10])), act == exp, int'(act), int'(exp));
    end

    // R8: stop insertion, cycle started at 95
    wait_to(100); stop_ni = 1'b0;
    wait_to(173); chk_pull("R8", 1'b0); chk_idle("R8", 1'b1);
    wait_to(214); chk_pull("R8", 1'b0);
    wait_to(215); stop_ni = 1'b1;
    wait_to(216); chk_pull("R8", 1'b1);
    a = 216;

    // R11: clock-run reply while busy, none while idle
    wait_to(a + 20); clkrun_req = 1'b1;
    wait_to(a + 21); chk("R11", clkrun_pull_o == 1'b1, int'(clkrun_pull_o), 1);
    wait_to(a + 22); chk("R11", clkrun_pull_o == 1'b1, int'(clkrun_pull_o), 1);
    clkrun_req = 1'b0;
    wait_to(a + 23); chk("R11", clkrun_pull_o == 1'b0, int'(clkrun_pull_o), 0);
    wait_to(a + 80); clkrun_req = 1'b1;
    wait_to(a + 82); chk("R11", clkrun_pull_o == 1'b0, int'(clkrun_pull_o), 0);
    clkrun_req = 1'b0;

    // R7, R5, R6: mode change to quiet after the start pulse
    b = a + 95;
    wait_to(b); chk_pull("R7", 1'b1);
    wait_to(b + 20); poll_mode_i = 1'b0;
    wait_to(b + 75); chk_pull("R5", 1'b1);
    wait_to(b + 76); chk_pull("R5", 1'b0);
    wait_to(b + 78); chk_pull("R6", 1'b1);
    c = b + 78;
    wait_to(c + 74); chk_pull("R4", 1'b1);
    wait_to(c + 75); chk_pull("R4", 1'b0);

    // R9: quiet mode waits for the peripheral
    wait_to(c + 100); chk_pull("R9", 1'b0); chk_idle("R9", 1'b1);
    wait_to(c + 110); periph_low = 1'b1;
    wait_to(c + 111); periph_low = 1'b0;
    chk_pull("R9", 1'b1);
    wait_to(c + 112); chk_idle("R10", 1'b0);
    wait_to(c + 117); chk_pull("R9", 1'b1);
    wait_to(c + 118); chk_pull("R9", 1'b0);
    wait_to(c + 120);
    chk("R3", frame_valid_o && frame_idx_o == 5'd0 && phase_o == 2'd0,
        {frame_valid_o, frame_idx_o, phase_o}, 8'h80);
    wait_to(c + 184); chk_pull("R4", 1'b1);
    wait_to(c + 185); chk_pull("R4", 1'b0); chk_idle("R10", 1'b0);
    wait_to(c + 186); chk_idle("R10", 1'b1);

    // R6: change while idle starts at once; R5: change inside start pulse
    wait_to(c + 200); poll_mode_i = 1'b1;
    f = c + 201;
    wait_to(f); chk_pull("R6", 1'b1);
    wait_to(f + 3); poll_mode_i = 1'b0;
    wait_to(f + 74); chk_pull("R5", 1'b1);
    wait_to(f + 75); chk_pull("R5", 1'b0);
    wait_to(f + 78); chk_pull("R5", 1'b0);
    wait_to(f + 95); chk_pull("R5", 1'b0); chk_idle("R5", 1'b1);

    // R1: reset mid-run, then self start with quiet pin
    wait_to(f + 100); rst_ni = 1'b0;
    wait_to(f + 101);
    chk("R1", !sirq_pull_o && !clkrun_pull_o && idle_o,
        {sirq_pull_o, clkrun_pull_o, idle_o}, 3'b001);
    wait_to(f + 102); rst_ni = 1'b1;
    g = f + 103;
    wait_to(g); chk_pull("R1", 1'b1);

    // R12: shutdown freezes in frame 6 turnaround
    wait_to(g + 30); shutdown_ni = 1'b0;
    wait_to(g + 31);
    chk("R12", !frame_valid_o && !sirq_pull_o, {frame_valid_o, sirq_pull_o}, 0);
    clkrun_req = 1'b1;
    wait_to(g + 33); chk("R12", clkrun_pull_o == 1'b0, int'(clkrun_pull_o), 0);
    wait_to(g + 34); clkrun_req = 1'b0;
    wait_to(g + 35); shutdown_ni = 1'b1;
    wait_to(g + 36);
    chk("R12", frame_valid_o && frame_idx_o == 5'd7 && phase_o == 2'd0 && !clkrun_pull_o,
        {clkrun_pull_o, frame_valid_o, frame_idx_o, phase_o}, 9'h09C);
    wait_to(g + 79); chk_pull("R12", 1'b1);
    wait_to(g + 80); chk_pull("R12", 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired at cycle %0d: act=0 exp=1", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule